// File: doc/BRIEF.md
# Passive Cell Balancing Controller

This block decides which series cell inputs of a battery stack have their bleed (bypass) switch closed. It produces one enable bit per input. It has two modes. In host mode, a command supplies an enable mask directly. A watchdog timer, driven by a one-second tick, switches the bypasses off once a programmed number of seconds has passed without a fresh command. In autonomous mode, a per-cell request vector comes from an external voltage comparison. The block picks cells from it so that no two chosen cells are neighbours and the number of chosen cells never exceeds a configured maximum.

Inputs flagged as interconnect sense points are never enabled. Measurement blanking is applied to the final mask without any register. It opens the bypass of the cell being converted and of both its neighbours. It also opens the top cell's bypass while the stack voltage is being converted. The block reports the elapsed balancing time in seconds.

The control is a three-state machine.
- `ST_IDLE` applies no bypass.
- `ST_HOST` applies the latched host mask.
- `ST_AUTO` applies the mask chosen from the requests, updated every cycle.

The transitions are named as follows.
- GO_AUTO: any state goes to `ST_AUTO` when the autonomous mode input is high.
- HOST_CMD: `ST_IDLE` goes to `ST_HOST` on a command when the limit is non-zero. The same transition restarts the timer when the block is already in `ST_HOST`.
- EXPIRE: `ST_HOST` goes to `ST_IDLE` on the tick that brings the timer to the limit.
- LIMIT_OFF: `ST_HOST` goes to `ST_IDLE` when the limit is zero.
- LEAVE_AUTO: `ST_AUTO` goes to `ST_IDLE` when the autonomous mode input is low.

Top module: `cell_bal_ctrl`

## Requirements
- R1: After reset, `bypass_en` is all zeros and `bal_time` is zero.
- R2: In host mode, a command with `host_cmd_valid` high and a non-zero `time_limit` makes `bypass_en` equal `host_cmd_mask` from the next clock edge. This holds even when the mask contains adjacent bits.
- R3: A bit set in `interconnect_mask` is never set in `bypass_en`. In host mode this applies to the mask latched at command time. In autonomous mode it applies to the selection.
- R4: In autonomous mode, the block scans requests from bit 0 upward. It selects a requested, non-interconnect cell when the cell just below it was not selected. The selection appears on `bypass_en` one edge after the block is in `ST_AUTO`. No two adjacent bits are ever selected.
- R5: In autonomous mode, the scan stops once `max_cells` cells are selected. A `max_cells` of 0 selects nothing.
- R6: In host mode, `bal_time` increments on each clock edge at which `tick_1s` is high. On the edge where the count reaches `time_limit`, the state goes to `ST_IDLE`, `bypass_en` becomes zero, and `bal_time` holds the limit.
- R7: A new host command resets `bal_time` to 0 and replaces the mask.
- R8: When `time_limit` is 0, a host command has no effect, and host balancing that is already running stops at the next edge.
- R9: While `meas_active` is high, the bits at index `meas_chan`, `meas_chan`-1 and `meas_chan`+1 of `bypass_en` are forced to 0 in the same cycle.
- R10: While `meas_stack` is high, the top bit (index N_CELLS-1) of `bypass_en` is forced to 0 in the same cycle.
- R11: Entering `ST_AUTO` resets `bal_time` to 0. In `ST_AUTO`, `bal_time` counts ticks.
- R12: Host commands have no effect in autonomous mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_auto | input | 1 | 1 = autonomous, 0 = host |
| host_cmd_valid | input | 1 | Host balancing command strobe |
| host_cmd_mask | input | N_CELLS | Cells the host wants bypassed |
| time_limit | input | TIMER_W | Host watchdog limit in seconds, 0 disables |
| tick_1s | input | 1 | One-second tick, one cycle wide |
| max_cells | input | CNT_W | Cap on simultaneously balanced cells (autonomous) |
| interconnect_mask | input | N_CELLS | Inputs that are interconnect sense points |
| auto_req | input | N_CELLS | Per-cell balance requests from voltage comparison |
| meas_active | input | 1 | A cell conversion is running |
| meas_chan | input | CH_W | Index of the cell being converted |
| meas_stack | input | 1 | Stack voltage conversion is running |
| bypass_en | output | N_CELLS | Final bypass switch enables |
| bal_time | output | TIMER_W | Elapsed balancing time in seconds |

## Verification
The bench builds the block with N_CELLS = 6 and TIMER_W = 8. With six inputs, both ends of the stack are within reach: the blanking window clipped at the bottom and top cells, and the stack blanking of the top cell. Six inputs also give enough cells for the scan to show both the adjacency rule and the cap on selected cells. Short limits of a few seconds let the host watchdog expire and restart within a few dozen cycles.

// File: rtl/cbal_pkg.sv
package cbal_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_HOST = 2'd1,
        ST_AUTO = 2'd2
    } cbal_state_e;

endpackage

// File: rtl/cbal_auto_sel.sv
module cbal_auto_sel #(
    parameter int N_CELLS = 16,
    parameter int CNT_W   = $clog2(N_CELLS + 1)
) (
    input  logic [N_CELLS-1:0] req_i,
    input  logic [N_CELLS-1:0] skip_i,
    input  logic [CNT_W-1:0]   max_i,
    output logic [N_CELLS-1:0] sel_o
);

    logic [CNT_W-1:0] picked;
    logic             below_taken;

    always_comb begin
        sel_o       = '0;
        picked      = '0;
        below_taken = 1'b0;
        for (int i = 0; i < N_CELLS; i++) begin
            if (req_i[i] && !skip_i[i] && !below_taken && (picked < max_i)) begin
                sel_o[i]    = 1'b1;
                picked      = picked + 1'b1;
                below_taken = 1'b1;
            end else begin
                below_taken = 1'b0;
            end
        end
    end

endmodule

// File: rtl/cbal_blank.sv
module cbal_blank #(
    parameter int N_CELLS = 16,
    parameter int CH_W    = (N_CELLS > 1) ? $clog2(N_CELLS) : 1
) (
    input  logic               active_i,
    input  logic [CH_W-1:0]    chan_i,
    input  logic               stack_i,
    output logic [N_CELLS-1:0] hold_off_o
);

    for (genvar i = 0; i < N_CELLS; i++) begin : g_cell
        logic own_hit;
        logic lo_hit;
        logic hi_hit;
        assign own_hit = (chan_i == CH_W'(i));
        if (i > 0) begin : g_lo
            assign lo_hit = (chan_i == CH_W'(i - 1));
        end else begin : g_lo_none
            assign lo_hit = 1'b0;
        end
        if (i < N_CELLS - 1) begin : g_hi
            assign hi_hit = (chan_i == CH_W'(i + 1));
            assign hold_off_o[i] = active_i && (own_hit || lo_hit || hi_hit);
        end else begin : g_top
            assign hi_hit = 1'b0;
            assign hold_off_o[i] = (active_i && (own_hit || lo_hit || hi_hit)) || stack_i;
        end
    end

endmodule

// File: rtl/cell_bal_ctrl.sv
module cell_bal_ctrl
    import cbal_pkg::*;
#(
    parameter int N_CELLS = 16,
    parameter int TIMER_W = 16,
    localparam int CNT_W  = $clog2(N_CELLS + 1),
    localparam int CH_W   = (N_CELLS > 1) ? $clog2(N_CELLS) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               mode_auto,
    input  logic               host_cmd_valid,
    input  logic [N_CELLS-1:0] host_cmd_mask,
    input  logic [TIMER_W-1:0] time_limit,
    input  logic               tick_1s,
    input  logic [CNT_W-1:0]   max_cells,
    input  logic [N_CELLS-1:0] interconnect_mask,
    input  logic [N_CELLS-1:0] auto_req,
    input  logic               meas_active,
    input  logic [CH_W-1:0]    meas_chan,
    input  logic               meas_stack,
    output logic [N_CELLS-1:0] bypass_en,
    output logic [TIMER_W-1:0] bal_time
);

    localparam logic [TIMER_W-1:0] TIMER_MAX = '1;

    cbal_state_e        state_q, state_d;
    logic [N_CELLS-1:0] sel_q, sel_d;
    logic [TIMER_W-1:0] timer_q, timer_d;
    logic [N_CELLS-1:0] auto_sel;
    logic [N_CELLS-1:0] hold_off;
    logic               cmd_ok;
    logic               reach_limit;
    logic [TIMER_W:0]   timer_inc;

    cbal_auto_sel #(.N_CELLS(N_CELLS), .CNT_W(CNT_W)) u_sel (
        .req_i  (auto_req),
        .skip_i (interconnect_mask),
        .max_i  (max_cells),
        .sel_o  (auto_sel)
    );

    cbal_blank #(.N_CELLS(N_CELLS), .CH_W(CH_W)) u_blank (
        .active_i   (meas_active),
        .chan_i     (meas_chan),
        .stack_i    (meas_stack),
        .hold_off_o (hold_off)
    );

    assign cmd_ok      = host_cmd_valid && !mode_auto && (time_limit != '0);
    assign timer_inc   = {1'b0, timer_q} + 1'b1;
    assign reach_limit = tick_1s && (timer_inc >= {1'b0, time_limit});

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            sel_q   <= '0;
            timer_q <= '0;
        end else begin
            state_q <= state_d;
            sel_q   <= sel_d;
            timer_q <= timer_d;
        end
    end

    // next state, mask and timer
    always_comb begin
        state_d = state_q;
        sel_d   = sel_q;
        timer_d = timer_q;
        unique case (state_q)
            ST_IDLE: begin
                sel_d = '0;
                if (mode_auto) begin
                    state_d = ST_AUTO;
                    timer_d = '0;
                end else if (cmd_ok) begin
                    state_d = ST_HOST;
                    sel_d   = host_cmd_mask & ~interconnect_mask;
                    timer_d = '0;
                end
            end
            ST_HOST: begin
                if (mode_auto) begin
                    state_d = ST_AUTO;
                    sel_d   = '0;
                    timer_d = '0;
                end else if (time_limit == '0) begin
                    state_d = ST_IDLE;
                    sel_d   = '0;
                end else if (cmd_ok) begin
                    sel_d   = host_cmd_mask & ~interconnect_mask;
                    timer_d = '0;
                end else if (reach_limit) begin
                    state_d = ST_IDLE;
                    sel_d   = '0;
                    timer_d = time_limit;
                end else if (tick_1s) begin
                    timer_d = timer_inc[TIMER_W-1:0];
                end
            end
            ST_AUTO: begin
                if (!mode_auto) begin
                    state_d = ST_IDLE;
                    sel_d   = '0;
                end else begin
                    sel_d = auto_sel;
                    if (tick_1s && timer_q != TIMER_MAX) begin
                        timer_d = timer_inc[TIMER_W-1:0];
                    end
                end
            end
            default: begin
                state_d = ST_IDLE;
                sel_d   = '0;
            end
        endcase
    end

    // outputs
    always_comb begin
        bypass_en = sel_q & ~hold_off;
        bal_time  = timer_q;
    end

    // R4
    auto_no_adjacent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_AUTO) |-> ((sel_q & (sel_q >> 1)) == '0));

    // R5
    auto_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_AUTO) && $past(state_q == ST_AUTO))
            |-> ($countones(sel_q) <= int'($past(max_cells))));

    // R6
    host_expire_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_HOST) && !mode_auto && !host_cmd_valid && tick_1s
            && (time_limit != '0) && ({1'b0, bal_time} + 1'b1 >= {1'b0, time_limit}))
            |=> ((state_q == ST_IDLE) && (bypass_en == '0)));

    // R8
    zero_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((time_limit == '0) && !mode_auto) |=> (state_q != ST_HOST));

    // R9
    meas_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (meas_active && (int'(meas_chan) < N_CELLS)) |-> (bypass_en[meas_chan] == 1'b0));

    // R10
    stack_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
        meas_stack |-> (bypass_en[N_CELLS-1] == 1'b0));

    // R7
    cmd_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_HOST) && cmd_ok) |=> (bal_time == '0));

endmodule

// File: tb/cell_bal_ctrl_tb.sv
module cell_bal_ctrl_tb;

    localparam int N  = 6;
    localparam int TW = 8;
    localparam int CW = $clog2(N + 1);
    localparam int HW = $clog2(N);

    logic          clk = 1'b0;
    logic          rst_n;
    logic          mode_auto;
    logic          host_cmd_valid;
    logic [N-1:0]  host_cmd_mask;
    logic [TW-1:0] time_limit;
    logic          tick_1s;
    logic [CW-1:0] max_cells;
    logic [N-1:0]  interconnect_mask;
    logic [N-1:0]  auto_req;
    logic          meas_active;
    logic [HW-1:0] meas_chan;
    logic          meas_stack;
    logic [N-1:0]  bypass_en;
    logic [TW-1:0] bal_time;

    int n_checks = 0;
    int n_fail   = 0;

    always #5 clk = ~clk;

    cell_bal_ctrl #(.N_CELLS(N), .TIMER_W(TW)) u_dut (
        .clk               (clk),
        .rst_n             (rst_n),
        .mode_auto         (mode_auto),
        .host_cmd_valid    (host_cmd_valid),
        .host_cmd_mask     (host_cmd_mask),
        .time_limit        (time_limit),
        .tick_1s           (tick_1s),
        .max_cells         (max_cells),
        .interconnect_mask (interconnect_mask),
        .auto_req          (auto_req),
        .meas_active       (meas_active),
        .meas_chan         (meas_chan),
        .meas_stack        (meas_stack),
        .bypass_en         (bypass_en),
        .bal_time          (bal_time)
    );

    // {req, interconnect, max, expected}
    typedef struct packed {
        logic [N-1:0]  req;
        logic [N-1:0]  ic;
        logic [CW-1:0] mx;
        logic [N-1:0]  exp_sel;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VECS [NV] = '{
        '{6'b111111, 6'b000000, 3'd6, 6'b010101},
        '{6'b111111, 6'b000000, 3'd2, 6'b000101},
        '{6'b110110, 6'b000000, 3'd6, 6'b010010},
        '{6'b111111, 6'b000001, 3'd6, 6'b101010},
        '{6'b001100, 6'b000000, 3'd1, 6'b000100},
        '{6'b111111, 6'b000000, 3'd0, 6'b000000},
        '{6'b100001, 6'b000000, 3'd6, 6'b100001},
        '{6'b101010, 6'b100000, 3'd6, 6'b001010}
    };

    task automatic check_mask(input string req, input logic [N-1:0] exp);
        n_checks++;
        if (bypass_en !== exp) begin
            n_fail++;
            $display("FAIL %s bypass_en actual=%b expected=%b", req, bypass_en, exp);
        end
    endtask

    task automatic check_time(input string req, input logic [TW-1:0] exp);
        n_checks++;
        if (bal_time !== exp) begin
            n_fail++;
            $display("FAIL %s bal_time actual=%0d expected=%0d", req, bal_time, exp);
        end
    endtask

    // one clock edge, then settle to mid-cycle
    task automatic step();
        @(posedge clk);
        #2;
    endtask

    task automatic host_cmd(input logic [N-1:0] m);
        host_cmd_mask  = m;
        host_cmd_valid = 1'b1;
        step();
        host_cmd_valid = 1'b0;
    endtask

    task automatic tick();
        tick_1s = 1'b1;
        step();
        tick_1s = 1'b0;
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        #2_000_000;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        rst_n = 1'b0; mode_auto = 1'b0; host_cmd_valid = 1'b0; host_cmd_mask = '0;
        time_limit = '0; tick_1s = 1'b0; max_cells = '0; interconnect_mask = '0;
        auto_req = '0; meas_active = 1'b0; meas_chan = '0; meas_stack = 1'b0;
        #23;
        check_mask("R1", '0);
        check_time("R1", '0);
        rst_n = 1'b1;
        step();

        // R8: zero limit, command ignored
        host_cmd(6'b000011);
        check_mask("R8", '0);

        // R2 adjacent host mask; R6 ticks
        time_limit = 8'd3;
        host_cmd(6'b000011);
        check_mask("R2", 6'b000011);
        check_time("R2", 8'd0);
        tick(); tick();
        check_time("R6", 8'd2);
        check_mask("R6", 6'b000011);
        // R7 restart
        host_cmd(6'b001100);
        check_mask("R7", 6'b001100);
        check_time("R7", 8'd0);
        tick(); tick();
        check_mask("R6", 6'b001100);
        tick();
        check_mask("R6", '0);
        check_time("R6", 8'd3);

        // R3 host interconnect filtered
        interconnect_mask = 6'b000001;
        host_cmd(6'b000011);
        check_mask("R3", 6'b000010);
        interconnect_mask = '0;

        // R8 limit drops to zero while running
        time_limit = 8'd0;
        step();
        check_mask("R8", '0);

        // R9 / R10 blanking, combinational
        time_limit = 8'd10;
        host_cmd(6'b111111);
        check_mask("R2", 6'b111111);
        meas_active = 1'b1; meas_chan = 3'd2; #1;
        check_mask("R9", 6'b110001);
        meas_chan = 3'd0; #1;
        check_mask("R9", 6'b111100);
        meas_chan = 3'd5; #1;
        check_mask("R9", 6'b001111);
        meas_active = 1'b0; meas_stack = 1'b1; #1;
        check_mask("R10", 6'b011111);
        meas_stack = 1'b0; #1;
        check_mask("R9", 6'b111111);

        // R11 entering auto resets time
        tick();
        check_time("R11", 8'd1);
        mode_auto = 1'b1;
        for (int v = 0; v < NV; v++) begin
            auto_req          = VECS[v].req;
            interconnect_mask = VECS[v].ic;
            max_cells         = VECS[v].mx;
            step(); step();
            check_mask("R4 R5 R3", VECS[v].exp_sel);
            if (v == 0) check_time("R11", 8'd0);
        end
        tick(); tick();
        check_time("R11", 8'd2);

        // R12 host command ignored in auto mode
        host_cmd(6'b111111);
        step();
        check_mask("R12", 6'b001010);
        check_time("R12", 8'd2);

        finish_run();
    end

endmodule